// File: doc/BRIEF.md
# Dual-Bus Inverting Port Latch

This block keeps one byte of storage that two independent bidirectional buses share. One bus faces the user system. The other faces a controller. Each bus has its own control inputs. A shared level-sensitive strobe admits writes from either side. The stored byte is held in user-bus polarity, so the controller side reads the bitwise complement. A byte written on one bus therefore reads back inverted on the other bus and unchanged on the bus that wrote it.

The tri-state pins appear as separate input, output and output-enable vectors for each bus. Writes are sampled on a fast system clock. The byte follows the selected bus on every cycle that the write condition holds, which approximates a transparent latch. A synchronous reset loads all ones, the power-up state. The controller-side select input is intended to come from a bank-select line of the controller, where it acts as one more address bit. A user-side write takes precedence: while the user side is writing, writes from the controller are blocked.

Top module: `dual_port_latch`

## Requirements
- R1: The user bus output enable `usrOe` is 1 exactly when `usrOutN`=0 and `usrInN`=1; it is 0 for every other combination.
- R2: When `usrInN`=0 and `strobe`=1, the byte on `usrDin` is stored, and `usrDout` shows it on the next cycle.
- R3: When `usrInN`=1 or `strobe`=0, the user bus stores nothing.
- R4: The controller bus output enable `ctlOe` is 1 exactly when `selN`, `rdN` and `wrN` are all 0.
- R5: When `selN`=0, `wrN`=1, `strobe`=1 and `usrInN`=1, the byte on `ctlDin` is stored, and `ctlDout` shows it unchanged on the next cycle.
- R6: When `usrInN`=0, the controller bus stores nothing, whatever `selN`, `wrN` and `strobe` are.
- R7: `ctlDout` is always the bitwise complement of `usrDout`, so a byte written on one bus reads back inverted on the other.
- R8: After reset the stored byte is all ones: `usrDout`=8'hFF and `ctlDout`=8'h00.
- R9: When `selN`=1, or `wrN`=0, or `strobe`=0, the controller bus stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset, loads all ones |
| strobe | input | 1 | shared write strobe, active high |
| usrInN | input | 1 | user input control, active low |
| usrOutN | input | 1 | user output control, active low |
| usrDin | input | 8 | user bus input data |
| usrDout | output | 8 | user bus output data (stored byte) |
| usrOe | output | 1 | user bus driver enable |
| selN | input | 1 | controller bank select, active low |
| rdN | input | 1 | controller read control, active low |
| wrN | input | 1 | controller write control; a high level with strobe writes |
| ctlDin | input | 8 | controller bus input data |
| ctlDout | output | 8 | controller bus output data (complement of stored byte) |
| ctlOe | output | 1 | controller bus driver enable |

## Verification
A user write and a controller write can be requested in the same cycle. This happens when strobe is high, `usrInN` is low, and the controller presents `selN`=0 with `wrN`=1. The bench drives different bytes on the two buses in that cycle and expects the user byte to be stored, with the controller byte blocked. It then releases `usrInN` to confirm that the controller byte is accepted once the inhibit is gone. Driver enables and the inversion are judged against a reference byte held inside the bench.

// File: rtl/dual_port_latch_pkg.sv
package dual_port_latch_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic usrWrite;
    logic ctlWrite;
  } latch_strobes_t;
endpackage

// File: rtl/dual_port_latch_ctrl.sv
module dual_port_latch_ctrl
  import dual_port_latch_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           strobe,
  input  logic           usrInN,
  input  logic           usrOutN,
  input  logic           selN,
  input  logic           rdN,
  input  logic           wrN,
  output latch_strobes_t strobes,
  output logic           usrOe,
  output logic           ctlOe
);
  always_comb begin
    strobes.usrWrite = strobe && !usrInN;
    strobes.ctlWrite = strobe && usrInN && !selN && wrN;
    usrOe = !usrOutN && usrInN;
    ctlOe = !selN && !rdN && !wrN;
  end

  // R6
  ctl_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    !usrInN |-> !strobes.ctlWrite);
  // R1
  usr_oe_chk: assert property (@(posedge clk) disable iff (rst)
    usrOe |-> (usrInN && !usrOutN));
  // R4
  ctl_oe_chk: assert property (@(posedge clk) disable iff (rst)
    ctlOe |-> (!selN && !rdN && !wrN));
endmodule

// File: rtl/dual_port_latch_data.sv
module dual_port_latch_data
  import dual_port_latch_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic           clk,
  input  logic           rst,
  input  latch_strobes_t strobes,
  input  logic [W-1:0]   usrDin,
  input  logic [W-1:0]   ctlDin,
  output logic [W-1:0]   usrDout,
  output logic [W-1:0]   ctlDout
);
  localparam logic [W-1:0] ONES = {W{1'b1}};
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) held <= ONES;
    else if (strobes.usrWrite) held <= usrDin;
    else if (strobes.ctlWrite) held <= ~ctlDin;
  end

  assign usrDout = held;
  assign ctlDout = ~held;

  // R3 / R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.usrWrite && !strobes.ctlWrite) |=> $stable(held));
  // R2
  usr_store_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.usrWrite |=> (usrDout == $past(usrDin)));
  // R5
  ctl_store_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.ctlWrite && !strobes.usrWrite) |=> (ctlDout == $past(ctlDin)));
  // R7
  invert_chk: assert property (@(posedge clk) (ctlDout ^ usrDout) == ONES);
endmodule

// File: rtl/dual_port_latch.sv
module dual_port_latch
  import dual_port_latch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              usrInN,
  input  logic              usrOutN,
  input  logic [DATA_W-1:0] usrDin,
  output logic [DATA_W-1:0] usrDout,
  output logic              usrOe,
  input  logic              selN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] ctlDin,
  output logic [DATA_W-1:0] ctlDout,
  output logic              ctlOe
);
  latch_strobes_t strobes;

  dual_port_latch_ctrl i_ctrl (
    .clk(clk), .rst(rst), .strobe(strobe), .usrInN(usrInN), .usrOutN(usrOutN),
    .selN(selN), .rdN(rdN), .wrN(wrN), .strobes(strobes),
    .usrOe(usrOe), .ctlOe(ctlOe)
  );

  dual_port_latch_data #(.W(DATA_W)) i_data (
    .clk(clk), .rst(rst), .strobes(strobes), .usrDin(usrDin), .ctlDin(ctlDin),
    .usrDout(usrDout), .ctlDout(ctlDout)
  );

  // R8
  reset_ones_chk: assert property (@(posedge clk)
    $past(rst) |-> (usrDout == {DATA_W{1'b1}}));
endmodule

// File: tb/test_dual_port_latch.sv
module test_dual_port_latch;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, strobe = 1'b0, usrInN = 1'b1, usrOutN = 1'b1;
  logic selN = 1'b1, rdN = 1'b1, wrN = 1'b0;
  logic [7:0] usrDin = '0, ctlDin = '0, usrDout, ctlDout;
  logic usrOe, ctlOe;
  logic [7:0] model;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_port_latch i_dual_port_latch (
    .clk(clk), .rst(rst), .strobe(strobe), .usrInN(usrInN), .usrOutN(usrOutN),
    .usrDin(usrDin), .usrDout(usrDout), .usrOe(usrOe), .selN(selN), .rdN(rdN),
    .wrN(wrN), .ctlDin(ctlDin), .ctlDout(ctlDout), .ctlOe(ctlOe)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    strobe = 0; usrInN = 1; selN = 1; wrN = 0; rdN = 1;
  endtask

  task automatic checkStore(string req);
    chk(req, usrDout, model);
    chk({req, "/R7"}, ctlDout, ~model);
  endtask

  task automatic testReset();
    rst = 1; tick(); tick(); rst = 0; #1;
    model = 8'hFF;
    checkStore("R8");
    usrInN = 1; usrOutN = 0; #1;
    chk("R8 oe", {7'd0, usrOe}, 8'd1);
    chk("R8 drive", usrDout, 8'hFF);
    usrOutN = 1;
  endtask

  task automatic testUsrOe();
    for (int i = 0; i < 4; i++) begin
      usrInN = i[1]; usrOutN = i[0]; #1;
      chk("R1", {7'd0, usrOe}, {7'd0, (i[0] == 1'b0) && (i[1] == 1'b1)});
    end
    usrInN = 1; usrOutN = 1;
  endtask

  task automatic testCtlOe();
    for (int i = 0; i < 8; i++) begin
      selN = i[2]; rdN = i[1]; wrN = i[0]; #1;
      chk("R4", {7'd0, ctlOe}, {7'd0, i == 0});
    end
    idle();
  endtask

  task automatic testUsrWrite();
    logic [7:0] pats [3] = '{8'h5A, 8'h00, 8'hC3};
    foreach (pats[k]) begin
      usrDin = pats[k]; usrInN = 0; strobe = 1; tick();
      model = pats[k]; checkStore("R2");
    end
    idle();
    usrDin = 8'h11; usrInN = 0; strobe = 0; tick(); checkStore("R3 strobe low");
    usrInN = 1; strobe = 1; tick(); checkStore("R3 usrIn high");
    idle();
  endtask

  task automatic testCtlWrite();
    ctlDin = 8'h3C; selN = 0; wrN = 1; strobe = 1; tick();
    model = ~8'h3C; checkStore("R5");
    chk("R5 ctl reads same", ctlDout, 8'h3C);
    ctlDin = 8'hA5; tick(); model = ~8'hA5; checkStore("R5 follow");
    idle();
    ctlDin = 8'h0F; selN = 1; wrN = 1; strobe = 1; tick(); checkStore("R9 sel high");
    selN = 0; wrN = 0; tick(); checkStore("R9 wr low");
    wrN = 1; strobe = 0; tick(); checkStore("R9 strobe low");
    idle();
  endtask

  task automatic testCollision();
    usrDin = 8'h96; ctlDin = 8'h12; usrInN = 0; selN = 0; wrN = 1; strobe = 1; tick();
    model = 8'h96; checkStore("R6 user wins");
    usrInN = 1; tick(); model = ~8'h12; checkStore("R6 released");
    idle();
    ctlDin = 8'h77; selN = 0; wrN = 1; strobe = 0; usrInN = 0; tick();
    strobe = 0; checkStore("R6 no strobe");
    idle();
  endtask

  task automatic testCrossInvert();
    usrDin = 8'hE1; usrInN = 0; strobe = 1; tick(); idle();
    selN = 0; rdN = 0; wrN = 0; #1;
    chk("R7 ctl read oe", {7'd0, ctlOe}, 8'd1);
    chk("R7 ctl reads inverse", ctlDout, 8'h1E);
    idle();
    ctlDin = 8'h81; selN = 0; wrN = 1; strobe = 1; tick(); idle();
    chk("R7 usr reads inverse", usrDout, 8'h7E);
    model = 8'h7E;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testUsrOe();
    testCtlOe();
    testUsrWrite();
    testCtlWrite();
    testCollision();
    testCrossInvert();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule